// File: doc/BRIEF.md
# Mask-Register Access Permission Checker

This block judges one system-register access aimed at a pair of trap-mask registers. One register belongs to the hypervisor level. The other is its alias, reached from the kernel level. The inputs are the access direction, the five encoding fields and the current privilege level, together with the configuration that governs this access: whether the feature exists, whether the monitor level exists and has enabled the masks, hypervisor enable, the three nested-virtualisation bits, host mode, the fine-grained trap controls and the extended-control enables. The block is purely combinational.

The result is exactly one of four verdicts: permitted, undefined, trap to the hypervisor level, or trap to the monitor level. A trap also reports its exception class. A permitted access also names its physical target: the hypervisor mask register, the kernel-level register, or a fixed slot in the nested-virtualisation memory page. The checks run in a fixed order, and the first one that applies sets the verdict. Register storage is outside this block.

Top module: `sra_perm_check`

## Requirements
- R1: `verdict` is always one-hot with bit 0 = permitted, bit 1 = undefined, bit 2 = trap to level 2, bit 3 = trap to level 3; `target` is nonzero exactly when bit 0 is set, coded 1 = hypervisor mask register, 2 = kernel-level register, 3 = memory slot.
- R2: When `feat_on` is 0, every access is undefined, whatever the level or encoding.
- R3: Every access from level 0 is undefined.
- R4: An encoding other than op0=3, CRn=1, CRm=4, op2=2 with op1=4 (hypervisor register) or op1=0 (kernel alias) is undefined.
- R5: A level-1 access to the hypervisor encoding traps to level 2 when `nest_bits[0]` is 1, and is undefined otherwise.
- R6: At level 2, for either encoding, when `top_present`=1 and `top_mask_en`=0, the access is undefined if `prio_undef`=1 and traps to level 3 otherwise.
- R7: A level-1 alias access with `hyp_en`=1 and `fgt_impl`=1 traps to level 2 when `top_present`=1 and `fgt_top_en`=0, or when the fine-grained allow bit for its direction (`fg_rd_allow` for reads, `fg_wr_allow` for writes) is 0. The bit for the other direction has no effect.
- R8: Failing that, a level-1 alias access with `hyp_en`=1 traps to level 2 when `xctl_avail`=0 or `xctl_mask_en`=0. Failing that, it traps to level 3 when `top_present`=1 and `top_mask_en`=0. The undefined case of R6 (prio_undef=1) comes before every level-1 alias check.
- R9: A level-1 alias access that passes every check is permitted to the memory slot when `nest_bits`=3'b111, and to the kernel-level register otherwise.
- R10: A permitted level-2 access to the hypervisor encoding targets the hypervisor register. A permitted level-2 alias access targets the hypervisor register when `host_mode`=1 and the kernel-level register when it is 0.
- R11: A level-3 access with a recognised encoding is always permitted, to the register its encoding names.
- R12: `exc_class` is 0x18 on either trap verdict and 0 otherwise; `slot_off` is 0x320 when the target is the memory slot and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| feat_on | input | 1 | Mask feature implemented |
| top_present | input | 1 | Monitor level exists |
| top_mask_en | input | 1 | Monitor-level enable for mask access |
| prio_undef | input | 1 | Undefined takes priority over a level-3 trap |
| hyp_en | input | 1 | Hypervisor level enabled in current state |
| nest_bits | input | 3 | Nested-virtualisation control bits |
| host_mode | input | 1 | Hypervisor runs as host |
| fgt_impl | input | 1 | Second fine-grained trap set implemented |
| fgt_top_en | input | 1 | Monitor enable for second fine-grained trap set |
| fg_rd_allow | input | 1 | Fine-grained read allow for the alias |
| fg_wr_allow | input | 1 | Fine-grained write allow for the alias |
| xctl_avail | input | 1 | Extended hypervisor control register usable |
| xctl_mask_en | input | 1 | Extended-control enable for mask access |
| verdict | output | 4 | One-hot result |
| target | output | 2 | Selected physical target when permitted |
| slot_off | output | 12 | Memory slot offset when target is the slot |
| exc_class | output | 6 | Exception class on a trap |

## Verification
The block holds no state, so every output is due in the cycle the inputs change. No register lies on any path. The bench changes inputs just after a falling clock edge, waits 1 ns for the logic to settle, and samples while the clock is still low, well before the next rising edge. Each scenario task compares all four outputs on every step, so the class and slot encodings are checked for every verdict. The checker evaluates its immediate assertions whenever an input changes.

// File: rtl/sra_pkg.sv
package sra_pkg;

   localparam int ENC_OP0     = 3;
   localparam int ENC_OP1_HYP = 4;
   localparam int ENC_OP1_GST = 0;
   localparam int ENC_CRN     = 1;
   localparam int ENC_CRM     = 4;
   localparam int ENC_OP2     = 2;
   localparam int TRAP_CLASS  = 'h18;
   localparam int NV_SLOT     = 'h320;

   typedef enum logic [1:0] {
      LVL_APP  = 2'd0,
      LVL_KERN = 2'd1,
      LVL_HYP  = 2'd2,
      LVL_MON  = 2'd3
   } lvl_e;

   typedef enum logic [1:0] {
      TGT_NONE    = 2'd0,
      TGT_HYP_REG = 2'd1,
      TGT_GST_REG = 2'd2,
      TGT_NV_SLOT = 2'd3
   } tgt_e;

   localparam logic [3:0] VD_OK    = 4'b0001;
   localparam logic [3:0] VD_UND   = 4'b0010;
   localparam logic [3:0] VD_TRAP2 = 4'b0100;
   localparam logic [3:0] VD_TRAP3 = 4'b1000;

   typedef struct packed {
      logic [3:0] vd;
      tgt_e       tgt;
   } decision_t;

   function automatic decision_t mk_dec(logic [3:0] vd, tgt_e tgt);
      decision_t d;
      d.vd  = vd;
      d.tgt = tgt;
      return d;
   endfunction

   // Level-2 gate applied by the monitor level before a permitted result.
   function automatic decision_t mon_gate(logic present, logic en,
                                          logic prio, decision_t pass);
      if (present && !en)
         return prio ? mk_dec(VD_UND, TGT_NONE) : mk_dec(VD_TRAP3, TGT_NONE);
      return pass;
   endfunction

endpackage

// File: rtl/sra_enc_match.sv
module sra_enc_match #(
   parameter int OP0     = sra_pkg::ENC_OP0,
   parameter int OP1_HYP = sra_pkg::ENC_OP1_HYP,
   parameter int OP1_GST = sra_pkg::ENC_OP1_GST,
   parameter int CRN     = sra_pkg::ENC_CRN,
   parameter int CRM     = sra_pkg::ENC_CRM,
   parameter int OP2     = sra_pkg::ENC_OP2
) (
   input  logic [1:0] op0,
   input  logic [2:0] op1,
   input  logic [3:0] crn,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   output logic       hit_hyp,
   output logic       hit_gst
);
   logic common;

   assign common  = (op0 == 2'(OP0)) && (crn == 4'(CRN)) &&
                    (crm == 4'(CRM)) && (op2 == 3'(OP2));
   assign hit_hyp = common && (op1 == 3'(OP1_HYP));
   assign hit_gst = common && (op1 == 3'(OP1_GST));
endmodule

// File: rtl/sra_hyp_path.sv
module sra_hyp_path
   import sra_pkg::*;
(
   input  logic [1:0] lvl,
   input  logic       nest_lo,
   input  logic       top_present,
   input  logic       top_mask_en,
   input  logic       prio_undef,
   output decision_t  dec
);
   always_comb begin
      dec = mk_dec(VD_UND, TGT_NONE);
      case (lvl)
         LVL_KERN: dec = nest_lo ? mk_dec(VD_TRAP2, TGT_NONE)
                                 : mk_dec(VD_UND, TGT_NONE);
         LVL_HYP:  dec = mon_gate(top_present, top_mask_en, prio_undef,
                                  mk_dec(VD_OK, TGT_HYP_REG));
         LVL_MON:  dec = mk_dec(VD_OK, TGT_HYP_REG);
         default:  dec = mk_dec(VD_UND, TGT_NONE);
      endcase
   end
endmodule

// File: rtl/sra_gst_path.sv
module sra_gst_path
   import sra_pkg::*;
#(
   parameter bit HAS_FGT = 1'b1
) (
   input  logic [1:0] lvl,
   input  logic       acc_wr,
   input  logic       top_present,
   input  logic       top_mask_en,
   input  logic       prio_undef,
   input  logic       hyp_en,
   input  logic [2:0] nest_bits,
   input  logic       host_mode,
   input  logic       fgt_impl,
   input  logic       fgt_top_en,
   input  logic       fg_rd_allow,
   input  logic       fg_wr_allow,
   input  logic       xctl_avail,
   input  logic       xctl_mask_en,
   output decision_t  dec
);
   logic fgt_trap;
   logic mon_block;
   logic xctl_trap;

   generate
      if (HAS_FGT) begin : g_fgt
         logic dir_allow;
         assign dir_allow = acc_wr ? fg_wr_allow : fg_rd_allow;
         assign fgt_trap  = hyp_en && fgt_impl &&
                            ((top_present && !fgt_top_en) || !dir_allow);
      end else begin : g_no_fgt
         assign fgt_trap = 1'b0;
      end
   endgenerate

   assign mon_block = top_present && !top_mask_en;
   assign xctl_trap = hyp_en && (!xctl_avail || !xctl_mask_en);

   always_comb begin
      dec = mk_dec(VD_UND, TGT_NONE);
      case (lvl)
         LVL_KERN: begin
            if (mon_block && prio_undef)
               dec = mk_dec(VD_UND, TGT_NONE);
            else if (fgt_trap)
               dec = mk_dec(VD_TRAP2, TGT_NONE);
            else if (xctl_trap)
               dec = mk_dec(VD_TRAP2, TGT_NONE);
            else if (mon_block)
               dec = mk_dec(VD_TRAP3, TGT_NONE);
            else if (nest_bits == 3'b111)
               dec = mk_dec(VD_OK, TGT_NV_SLOT);
            else
               dec = mk_dec(VD_OK, TGT_GST_REG);
         end
         LVL_HYP:  dec = mon_gate(top_present, top_mask_en, prio_undef,
                                  mk_dec(VD_OK, host_mode ? TGT_HYP_REG
                                                          : TGT_GST_REG));
         LVL_MON:  dec = mk_dec(VD_OK, TGT_GST_REG);
         default:  dec = mk_dec(VD_UND, TGT_NONE);
      endcase
   end
endmodule

// File: rtl/sra_perm_check.sv
module sra_perm_check
   import sra_pkg::*;
#(
   parameter int OP0     = ENC_OP0,
   parameter int OP1_HYP = ENC_OP1_HYP,
   parameter int OP1_GST = ENC_OP1_GST,
   parameter int CRN     = ENC_CRN,
   parameter int CRM     = ENC_CRM,
   parameter int OP2     = ENC_OP2,
   parameter int SLOT_W  = 12,
   parameter int CLASS_W = 6,
   parameter bit HAS_FGT = 1'b1
) (
   input  logic                acc_wr,
   input  logic [1:0]          acc_op0,
   input  logic [2:0]          acc_op1,
   input  logic [3:0]          acc_crn,
   input  logic [3:0]          acc_crm,
   input  logic [2:0]          acc_op2,
   input  logic [1:0]          cur_lvl,
   input  logic                feat_on,
   input  logic                top_present,
   input  logic                top_mask_en,
   input  logic                prio_undef,
   input  logic                hyp_en,
   input  logic [2:0]          nest_bits,
   input  logic                host_mode,
   input  logic                fgt_impl,
   input  logic                fgt_top_en,
   input  logic                fg_rd_allow,
   input  logic                fg_wr_allow,
   input  logic                xctl_avail,
   input  logic                xctl_mask_en,
   output logic [3:0]          verdict,
   output logic [1:0]          target,
   output logic [SLOT_W-1:0]   slot_off,
   output logic [CLASS_W-1:0]  exc_class
);
   localparam logic [CLASS_W-1:0] CLASS_VAL = CLASS_W'(TRAP_CLASS);
   localparam logic [SLOT_W-1:0]  SLOT_VAL  = SLOT_W'(NV_SLOT);

   generate
      if (OP1_HYP == OP1_GST) begin : g_bad_enc
         $error("sra_perm_check: the two encodings must differ in op1");
      end
      if (TRAP_CLASS >= (1 << CLASS_W)) begin : g_bad_class
         $error("sra_perm_check: CLASS_W too narrow for the trap class");
      end
      if (NV_SLOT >= (1 << SLOT_W)) begin : g_bad_slot
         $error("sra_perm_check: SLOT_W too narrow for the slot offset");
      end
   endgenerate

   logic      hit_hyp;
   logic      hit_gst;
   decision_t dec_hyp;
   decision_t dec_gst;
   decision_t dec;

   sra_enc_match #(
      .OP0(OP0), .OP1_HYP(OP1_HYP), .OP1_GST(OP1_GST),
      .CRN(CRN), .CRM(CRM), .OP2(OP2)
   ) i_match (
      .op0(acc_op0), .op1(acc_op1), .crn(acc_crn), .crm(acc_crm),
      .op2(acc_op2), .hit_hyp(hit_hyp), .hit_gst(hit_gst)
   );

   sra_hyp_path i_hyp (
      .lvl(cur_lvl), .nest_lo(nest_bits[0]), .top_present(top_present),
      .top_mask_en(top_mask_en), .prio_undef(prio_undef), .dec(dec_hyp)
   );

   sra_gst_path #(.HAS_FGT(HAS_FGT)) i_gst (
      .lvl(cur_lvl), .acc_wr(acc_wr), .top_present(top_present),
      .top_mask_en(top_mask_en), .prio_undef(prio_undef), .hyp_en(hyp_en),
      .nest_bits(nest_bits), .host_mode(host_mode), .fgt_impl(fgt_impl),
      .fgt_top_en(fgt_top_en), .fg_rd_allow(fg_rd_allow),
      .fg_wr_allow(fg_wr_allow), .xctl_avail(xctl_avail),
      .xctl_mask_en(xctl_mask_en), .dec(dec_gst)
   );

   always_comb begin
      if (!feat_on || (cur_lvl == LVL_APP) || !(hit_hyp || hit_gst))
         dec = mk_dec(VD_UND, TGT_NONE);
      else if (hit_hyp)
         dec = dec_hyp;
      else
         dec = dec_gst;
   end

   assign verdict   = dec.vd;
   assign target    = dec.tgt;
   assign exc_class = ((dec.vd == VD_TRAP2) || (dec.vd == VD_TRAP3))
                      ? CLASS_VAL : '0;
   assign slot_off  = (dec.tgt == TGT_NV_SLOT) ? SLOT_VAL : '0;
endmodule

// File: rtl/sra_perm_check_sva.sv
module sra_perm_check_sva
   import sra_pkg::*;
(
   input logic [1:0]  acc_op0,
   input logic [2:0]  acc_op1,
   input logic [3:0]  acc_crn,
   input logic [3:0]  acc_crm,
   input logic [2:0]  acc_op2,
   input logic [1:0]  cur_lvl,
   input logic        feat_on,
   input logic [2:0]  nest_bits,
   input logic [3:0]  verdict,
   input logic [1:0]  target,
   input logic [11:0] slot_off,
   input logic [5:0]  exc_class
);
   logic known_enc;

   assign known_enc = (acc_op0 == 2'(ENC_OP0)) && (acc_crn == 4'(ENC_CRN)) &&
                      (acc_crm == 4'(ENC_CRM)) && (acc_op2 == 3'(ENC_OP2)) &&
                      ((acc_op1 == 3'(ENC_OP1_HYP)) ||
                       (acc_op1 == 3'(ENC_OP1_GST)));

   always_comb begin
      a_r1_onehot: assert ($onehot(verdict))
         else $error("R1 verdict not one-hot");
      a_r1_target: assert ((target != 2'd0) == verdict[0])
         else $error("R1 target inconsistent with verdict");
      if (!feat_on)
         a_r2_feat_off: assert (verdict == VD_UND)
            else $error("R2 feature off not undefined");
      if (cur_lvl == 2'd0)
         a_r3_lvl0: assert (verdict == VD_UND)
            else $error("R3 level 0 not undefined");
      if (!known_enc)
         a_r4_foreign: assert (verdict == VD_UND)
            else $error("R4 foreign encoding not undefined");
      if (target == 2'd3)
         a_r9_slot_src: assert ((cur_lvl == 2'd1) && (nest_bits == 3'b111))
            else $error("R9 memory slot chosen outside level 1 full nesting");
      if (feat_on && known_enc && (cur_lvl == 2'd3))
         a_r11_mon_ok: assert (verdict == VD_OK)
            else $error("R11 level 3 access not permitted");
      a_r12_class: assert (exc_class == ((verdict[2] || verdict[3]) ? 6'h18 : 6'h0))
         else $error("R12 exception class wrong");
      a_r12_slot: assert (slot_off == ((target == 2'd3) ? 12'h320 : 12'h0))
         else $error("R12 slot offset wrong");
   end
endmodule

bind sra_perm_check sra_perm_check_sva i_sva (
   .acc_op0(acc_op0), .acc_op1(acc_op1), .acc_crn(acc_crn),
   .acc_crm(acc_crm), .acc_op2(acc_op2), .cur_lvl(cur_lvl),
   .feat_on(feat_on), .nest_bits(nest_bits), .verdict(verdict),
   .target(target), .slot_off(slot_off), .exc_class(exc_class)
);

// File: tb/test_sra_perm_check.sv
`timescale 1ns/1ps
module test_sra_perm_check;
   localparam logic [3:0] V_OK = 4'b0001, V_UND = 4'b0010,
                          V_T2 = 4'b0100, V_T3  = 4'b1000;
   localparam logic [1:0] T_NONE = 2'd0, T_HYP = 2'd1, T_GST = 2'd2, T_MEM = 2'd3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        acc_wr;
   logic [1:0]  acc_op0;
   logic [2:0]  acc_op1;
   logic [3:0]  acc_crn, acc_crm;
   logic [2:0]  acc_op2;
   logic [1:0]  cur_lvl;
   logic        feat_on, top_present, top_mask_en, prio_undef, hyp_en;
   logic [2:0]  nest_bits;
   logic        host_mode, fgt_impl, fgt_top_en, fg_rd_allow, fg_wr_allow;
   logic        xctl_avail, xctl_mask_en;
   logic [3:0]  verdict;
   logic [1:0]  target;
   logic [11:0] slot_off;
   logic [5:0]  exc_class;

   int n_run  = 0;
   int n_fail = 0;

   sra_perm_check i_sra_perm_check (.*);

   task automatic base(input logic [2:0] op1, input logic [1:0] lvl);
      @(negedge clk);
      acc_wr = 1'b0; acc_op0 = 2'd3; acc_op1 = op1; acc_crn = 4'd1;
      acc_crm = 4'd4; acc_op2 = 3'd2; cur_lvl = lvl;
      feat_on = 1'b1; top_present = 1'b1; top_mask_en = 1'b1;
      prio_undef = 1'b0; hyp_en = 1'b1; nest_bits = 3'b000;
      host_mode = 1'b0; fgt_impl = 1'b1; fgt_top_en = 1'b1;
      fg_rd_allow = 1'b1; fg_wr_allow = 1'b1;
      xctl_avail = 1'b1; xctl_mask_en = 1'b1;
   endtask

   task automatic chk(input string req, input logic [3:0] ev, input logic [1:0] et);
      logic [5:0]  ec;
      logic [11:0] es;
      #1;
      ec = (ev == V_T2 || ev == V_T3) ? 6'h18 : 6'h0;
      es = (et == T_MEM) ? 12'h320 : 12'h0;
      n_run++;
      if (verdict !== ev || target !== et) begin
         n_fail++;
         $display("FAIL %s: verdict/target %b/%0d expected %b/%0d", req, verdict, target, ev, et);
      end
      n_run++;
      if (exc_class !== ec || slot_off !== es) begin
         n_fail++;
         $display("FAIL R12 (%s): class/slot %h/%h expected %h/%h", req, exc_class, slot_off, ec, es);
      end
   endtask

   task automatic t_idle;
      base(3'd4, 2'd3); chk("R1 idle", V_OK, T_HYP);
   endtask

   task automatic t_feature_off;
      base(3'd4, 2'd3); feat_on = 0; chk("R2 hyp enc", V_UND, T_NONE);
      base(3'd0, 2'd1); feat_on = 0; chk("R2 alias enc", V_UND, T_NONE);
   endtask

   task automatic t_level0;
      base(3'd4, 2'd0); chk("R3 hyp enc", V_UND, T_NONE);
      base(3'd0, 2'd0); acc_wr = 1; chk("R3 alias write", V_UND, T_NONE);
   endtask

   task automatic t_foreign;
      base(3'd4, 2'd3); acc_op2 = 3'd3; chk("R4 op2", V_UND, T_NONE);
      base(3'd1, 2'd3); chk("R4 op1", V_UND, T_NONE);
      base(3'd0, 2'd3); acc_op0 = 2'd2; chk("R4 op0", V_UND, T_NONE);
   endtask

   task automatic t_kern_hyp;
      base(3'd4, 2'd1); nest_bits = 3'b001; chk("R5 nest lo", V_T2, T_NONE);
      base(3'd4, 2'd1); nest_bits = 3'b110; chk("R5 nest hi only", V_UND, T_NONE);
   endtask

   task automatic t_hyp_gate;
      base(3'd4, 2'd2); top_mask_en = 0; prio_undef = 1; chk("R6 prio", V_UND, T_NONE);
      base(3'd4, 2'd2); top_mask_en = 0; chk("R6 trap3", V_T3, T_NONE);
      base(3'd0, 2'd2); top_mask_en = 0; chk("R6 alias trap3", V_T3, T_NONE);
      base(3'd4, 2'd2); top_present = 0; top_mask_en = 0; chk("R6 no monitor", V_OK, T_HYP);
   endtask

   task automatic t_fine;
      base(3'd0, 2'd1); fg_rd_allow = 0; chk("R7 read bit", V_T2, T_NONE);
      base(3'd0, 2'd1); fg_rd_allow = 0; acc_wr = 1; chk("R7 other dir", V_OK, T_GST);
      base(3'd0, 2'd1); fg_wr_allow = 0; acc_wr = 1; chk("R7 write bit", V_T2, T_NONE);
      base(3'd0, 2'd1); fgt_top_en = 0; chk("R7 top enable", V_T2, T_NONE);
      base(3'd0, 2'd1); fgt_impl = 0; fg_rd_allow = 0; chk("R7 not impl", V_OK, T_GST);
      base(3'd0, 2'd1); hyp_en = 0; fg_rd_allow = 0; chk("R7 hyp off", V_OK, T_GST);
   endtask

   task automatic t_xctl;
      base(3'd0, 2'd1); xctl_mask_en = 0; chk("R8 mask en", V_T2, T_NONE);
      base(3'd0, 2'd1); xctl_avail = 0; chk("R8 avail", V_T2, T_NONE);
      base(3'd0, 2'd1); hyp_en = 0; xctl_avail = 0; chk("R8 hyp off", V_OK, T_GST);
      base(3'd0, 2'd1); top_mask_en = 0; chk("R8 trap3", V_T3, T_NONE);
      base(3'd0, 2'd1); top_mask_en = 0; xctl_avail = 0; chk("R8 trap2 first", V_T2, T_NONE);
      base(3'd0, 2'd1); top_mask_en = 0; prio_undef = 1; fg_rd_allow = 0;
      chk("R8 undef first", V_UND, T_NONE);
   endtask

   task automatic t_nested;
      base(3'd0, 2'd1); nest_bits = 3'b111; chk("R9 slot", V_OK, T_MEM);
      base(3'd0, 2'd1); nest_bits = 3'b011; chk("R9 partial", V_OK, T_GST);
      base(3'd0, 2'd1); nest_bits = 3'b111; xctl_mask_en = 0; chk("R9 trap wins", V_T2, T_NONE);
   endtask

   task automatic t_host;
      base(3'd0, 2'd2); host_mode = 1; chk("R10 host alias", V_OK, T_HYP);
      base(3'd0, 2'd2); chk("R10 plain alias", V_OK, T_GST);
      base(3'd4, 2'd2); host_mode = 1; chk("R10 hyp enc", V_OK, T_HYP);
   endtask

   task automatic t_monitor;
      base(3'd4, 2'd3); top_mask_en = 0; prio_undef = 1; chk("R11 hyp enc", V_OK, T_HYP);
      base(3'd0, 2'd3); top_mask_en = 0; host_mode = 1; nest_bits = 3'b111;
      chk("R11 alias", V_OK, T_GST);
   endtask

   initial begin
      #20000;
      n_run++; n_fail++;
      $display("FAIL watchdog: expired, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_idle();
      t_feature_off();
      t_level0();
      t_foreign();
      t_kern_hyp();
      t_hyp_gate();
      t_fine();
      t_xctl();
      t_nested();
      t_host();
      t_monitor();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule